// File: doc/BRIEF.md
# Dual-Metric Acquisition Signal Detector

This block decides whether a spread-spectrum signal is present from a stream of correlator outputs. Each sample carries a magnitude and a phase and arrives with a valid flag. The stream runs at two samples per chip, so an 11-chip symbol spans 22 valid samples. For each symbol the block picks the on-time sample, which is the strongest one. It reports that sample together with its two neighbours, which timing tracking uses.

Over a window of 16 symbols the block builds two measures. The first is the mean on-time amplitude. The second is a scaled variance of the differential phase, meaning the change in phase from one symbol peak to the next. That difference strips the scrambling phase. Each measure is compared with its own 16-bit threshold, loaded one byte at a time. The two comparisons point in opposite directions: amplitude must reach its threshold and phase variance must not exceed its threshold. Carrier sense is raised for a window only when both tests pass.

Setting the amplitude threshold to zero or the phase threshold to all ones disables that test. A system can then tune each threshold against noise on its own.

Top module: `acq_sig_detect`

## Requirements
- R1: Samples with `smp_valid` low are ignored. Every 22 valid samples form one symbol. `sym_valid` pulses for exactly one cycle, in the cycle after the 22nd valid sample is taken.
- R2: `ontime_mag` and `ontime_phase` belong to the sample of largest magnitude in the symbol. When several samples tie, the earliest of them is reported.
- R3: `early_mag` is the valid sample taken just before the on-time sample. When the on-time sample is the first of its symbol, this is the last sample of the previous symbol, or 0 if no sample has been taken since reset.
- R4: `late_mag` is the valid sample taken just after the on-time sample. It is 0 when the on-time sample is the last of its symbol.
- R5: Every 16 symbols, `win_valid` pulses for one cycle, in the cycle after the 16th `sym_valid`. `amp_metric` is then the sum of the 16 on-time magnitudes divided by 16 and rounded down.
- R6: The differential phase d is the on-time phase minus the previous symbol's on-time phase, taken modulo 256 and read as a signed 8-bit value. The previous phase is 0 after reset and carries across window boundaries.
- R7: `var_metric` is (16·Σd² − (Σd)²) shifted right by 7 over the window's 16 values of d. Results above 65535 saturate to 65535.
- R8: A write with `cfg_we` high loads `cfg_wdata` into one byte selected by `cfg_addr`:
  - 0 selects the amplitude threshold low byte.
  - 1 selects the amplitude threshold high byte.
  - 2 selects the phase threshold low byte.
  - 3 selects the phase threshold high byte.
  
  A write leaves the other bytes unchanged. After reset the amplitude threshold is 0x0000 and the phase threshold is 0xFFFF.
- R9: With each `win_valid` pulse, `carrier_sense` becomes 1 only if `amp_metric` ≥ the amplitude threshold and `var_metric` ≤ the phase threshold. Otherwise it becomes 0. It holds its value between pulses and is 0 after reset.
- R10: An amplitude threshold of 0 makes the amplitude test always pass. A phase threshold of 0xFFFF makes the phase test always pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_mag | input | 16 | Correlator output magnitude |
| smp_phase | input | 8 | Correlator output phase, 256 steps per turn |
| cfg_we | input | 1 | Threshold byte write strobe |
| cfg_addr | input | 2 | Threshold byte select |
| cfg_wdata | input | 8 | Threshold byte value |
| sym_valid | output | 1 | Per-symbol result strobe |
| ontime_mag | output | 16 | Peak magnitude of the symbol |
| ontime_phase | output | 8 | Phase at the peak |
| early_mag | output | 16 | Sample before the peak |
| late_mag | output | 16 | Sample after the peak |
| win_valid | output | 1 | Window result strobe |
| amp_metric | output | 16 | Mean peak amplitude of the window |
| var_metric | output | 16 | Scaled differential-phase variance |
| carrier_sense | output | 1 | Both tests passed on the last window |

## Verification
The hardest cases to reach from the ports are where the peak lies on a symbol edge. When the peak is the first sample, its early neighbour belongs to the previous symbol. When the peak is the last sample, there is no late neighbour. The directed symbols place the peak at every fifth position modulo 22, which lands on both edges within one window. Some symbols also carry a later sample of equal magnitude, to test tie handling.

The opposing threshold directions are tested at their exact boundaries:
- Alternating ±64 phase steps give a known variance of 8192. The phase threshold is set one below that value and then equal to it.
- The amplitude threshold is set equal to a constant peak and then one above it. This change rewrites only the low byte.

Invalid cycles carrying full-scale junk are mixed into one window. Any junk that got through would become the peak.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int THR_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CFG_AMP_LO = 2'd0,
    CFG_AMP_HI = 2'd1,
    CFG_PH_LO  = 2'd2,
    CFG_PH_HI  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/acq_thr_regs.sv
module acq_thr_regs
  import acq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [THR_W-1:0]  amp_thr,
  output logic [THR_W-1:0]  ph_thr
);
  localparam int NBYTE = THR_W / BYTE_W;

  logic [1:0][THR_W-1:0] thr_q;

  // two thresholds, each split into byte lanes; lane t*NBYTE+b is addressed directly
  for (genvar t = 0; t < 2; t++) begin : g_thr
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst)
          thr_q[t][b*BYTE_W +: BYTE_W] <= (t == 0) ? '0 : '1;
        else if (cfg_we && (cfg_addr == 2'(t*NBYTE + b)))
          thr_q[t][b*BYTE_W +: BYTE_W] <= cfg_wdata;
      end
    end
  end

  assign amp_thr = thr_q[0];
  assign ph_thr  = thr_q[1];

  // R8
  amp_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == CFG_AMP_HI) |=> (amp_thr[15:8] == $past(cfg_wdata)));
  // R8
  ph_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == CFG_PH_LO) |=> (ph_thr[7:0] == $past(cfg_wdata)));
endmodule

// File: rtl/acq_peak_pick.sv
module acq_peak_pick #(
  parameter int MAG_W = 16,
  parameter int PH_W  = 8,
  parameter int SPS   = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [MAG_W-1:0] in_mag,
  input  logic [PH_W-1:0]  in_ph,
  output logic             sym_stb,
  output logic [MAG_W-1:0] on_mag,
  output logic [PH_W-1:0]  on_ph,
  output logic [MAG_W-1:0] early_mag,
  output logic [MAG_W-1:0] late_mag
);
  localparam int CNT_W = $clog2(SPS);

  logic [CNT_W-1:0] idx;
  logic [MAG_W-1:0] last_mag, pk_mag, pk_early, pk_late;
  logic [PH_W-1:0]  pk_ph;
  logic             late_pend;
  logic             first_s, last_s, take;

  assign first_s = (idx == '0);
  assign last_s  = (idx == CNT_W'(SPS - 1));
  assign take    = first_s || (in_mag > pk_mag);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      last_mag  <= '0;
      pk_mag    <= '0;
      pk_ph     <= '0;
      pk_early  <= '0;
      pk_late   <= '0;
      late_pend <= 1'b0;
      sym_stb   <= 1'b0;
      on_mag    <= '0;
      on_ph     <= '0;
      early_mag <= '0;
      late_mag  <= '0;
    end else begin
      sym_stb <= 1'b0;
      if (in_vld) begin
        last_mag <= in_mag;
        idx      <= last_s ? '0 : idx + CNT_W'(1);
        if (late_pend) begin
          pk_late   <= in_mag;
          late_pend <= 1'b0;
        end
        if (take) begin
          pk_mag    <= in_mag;
          pk_ph     <= in_ph;
          pk_early  <= last_mag;
          pk_late   <= '0;
          late_pend <= 1'b1;
        end
        if (last_s) begin
          sym_stb   <= 1'b1;
          on_mag    <= take ? in_mag : pk_mag;
          on_ph     <= take ? in_ph : pk_ph;
          early_mag <= take ? last_mag : pk_early;
          late_mag  <= take ? '0 : (late_pend ? in_mag : pk_late);
          late_pend <= 1'b0;
        end
      end
    end
  end

  // R1
  sym_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sym_stb |=> !sym_stb);
  // R2
  peak_ge_late_chk: assert property (@(posedge clk) disable iff (rst)
    sym_stb |-> (on_mag >= late_mag));
endmodule

// File: rtl/acq_win_stats.sv
module acq_win_stats
  import acq_pkg::*;
#(
  parameter int MAG_W     = 16,
  parameter int PH_W      = 8,
  parameter int WIN       = 16,
  parameter int VAR_SHIFT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_stb,
  input  logic [MAG_W-1:0] on_mag,
  input  logic [PH_W-1:0]  on_ph,
  input  logic [THR_W-1:0] amp_thr,
  input  logic [THR_W-1:0] ph_thr,
  output logic             win_stb,
  output logic [THR_W-1:0] amp_met,
  output logic [THR_W-1:0] var_met,
  output logic             crs
);
  localparam int WLOG  = $clog2(WIN);
  localparam int SA_W  = MAG_W + WLOG;
  localparam int SX_W  = PH_W + WLOG;
  localparam int X2_W  = 2 * PH_W + WLOG;
  localparam int RAW_W = X2_W + WLOG;

  logic [WLOG-1:0]     wcnt;
  logic [PH_W-1:0]     prev_ph;
  logic [SA_W-1:0]     sum_a;
  logic [SX_W-1:0]     sum_x;
  logic [X2_W-1:0]     sum_x2;

  logic [PH_W-1:0]     d_u, d_abs;
  logic [2*PH_W-1:0]   d_sq;
  logic [SA_W-1:0]     sum_a_n;
  logic [SX_W-1:0]     sum_x_n, sx_abs;
  logic [X2_W-1:0]     sum_x2_n;
  logic [2*SX_W-1:0]   sx_sq;
  logic [RAW_W-1:0]    raw, shifted;
  logic [THR_W-1:0]    amp_n, var_n;
  logic                win_end;

  // wrapped phase difference, two's complement
  assign d_u      = on_ph - prev_ph;
  assign d_abs    = d_u[PH_W-1] ? (~d_u + PH_W'(1)) : d_u;
  assign d_sq     = {{PH_W{1'b0}}, d_abs} * {{PH_W{1'b0}}, d_abs};
  assign sum_a_n  = sum_a + SA_W'(on_mag);
  assign sum_x_n  = sum_x + {{WLOG{d_u[PH_W-1]}}, d_u};
  assign sum_x2_n = sum_x2 + X2_W'(d_sq);
  assign sx_abs   = sum_x_n[SX_W-1] ? (~sum_x_n + SX_W'(1)) : sum_x_n;
  assign sx_sq    = {{SX_W{1'b0}}, sx_abs} * {{SX_W{1'b0}}, sx_abs};
  assign raw      = {sum_x2_n, {WLOG{1'b0}}} - RAW_W'(sx_sq);
  assign shifted  = raw >> VAR_SHIFT;
  assign var_n    = (shifted > RAW_W'({THR_W{1'b1}})) ? '1 : THR_W'(shifted);
  assign amp_n    = THR_W'(sum_a_n >> WLOG);
  assign win_end  = (wcnt == WLOG'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt    <= '0;
      prev_ph <= '0;
      sum_a   <= '0;
      sum_x   <= '0;
      sum_x2  <= '0;
      win_stb <= 1'b0;
      amp_met <= '0;
      var_met <= '0;
      crs     <= 1'b0;
    end else begin
      win_stb <= 1'b0;
      if (sym_stb) begin
        prev_ph <= on_ph;
        wcnt    <= win_end ? '0 : wcnt + WLOG'(1);
        if (win_end) begin
          sum_a   <= '0;
          sum_x   <= '0;
          sum_x2  <= '0;
          win_stb <= 1'b1;
          amp_met <= amp_n;
          var_met <= var_n;
          crs     <= (amp_n >= amp_thr) && (var_n <= ph_thr);
        end else begin
          sum_a  <= sum_a_n;
          sum_x  <= sum_x_n;
          sum_x2 <= sum_x2_n;
        end
      end
    end
  end

  // R5
  win_after_sym_chk: assert property (@(posedge clk) disable iff (rst)
    win_stb |-> $past(sym_stb));
  // R9
  crs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_stb |-> $stable(crs));
  // R9
  crs_decide_chk: assert property (@(posedge clk) disable iff (rst)
    win_stb |-> (crs == ((amp_met >= $past(amp_thr)) && (var_met <= $past(ph_thr)))));
endmodule

// File: rtl/acq_sig_detect.sv
module acq_sig_detect
  import acq_pkg::*;
#(
  parameter int MAG_W     = 16,
  parameter int PH_W      = 8,
  parameter int SPS       = 22,
  parameter int WIN       = 16,
  parameter int VAR_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [MAG_W-1:0]  smp_mag,
  input  logic [PH_W-1:0]   smp_phase,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic              sym_valid,
  output logic [MAG_W-1:0]  ontime_mag,
  output logic [PH_W-1:0]   ontime_phase,
  output logic [MAG_W-1:0]  early_mag,
  output logic [MAG_W-1:0]  late_mag,
  output logic              win_valid,
  output logic [THR_W-1:0]  amp_metric,
  output logic [THR_W-1:0]  var_metric,
  output logic              carrier_sense
);
  logic [THR_W-1:0] amp_thr, ph_thr;

  acq_thr_regs u_thr (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .amp_thr   (amp_thr),
    .ph_thr    (ph_thr)
  );

  acq_peak_pick #(.MAG_W(MAG_W), .PH_W(PH_W), .SPS(SPS)) u_peak (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (smp_valid),
    .in_mag    (smp_mag),
    .in_ph     (smp_phase),
    .sym_stb   (sym_valid),
    .on_mag    (ontime_mag),
    .on_ph     (ontime_phase),
    .early_mag (early_mag),
    .late_mag  (late_mag)
  );

  acq_win_stats #(.MAG_W(MAG_W), .PH_W(PH_W), .WIN(WIN), .VAR_SHIFT(VAR_SHIFT)) u_stats (
    .clk     (clk),
    .rst     (rst),
    .sym_stb (sym_valid),
    .on_mag  (ontime_mag),
    .on_ph   (ontime_phase),
    .amp_thr (amp_thr),
    .ph_thr  (ph_thr),
    .win_stb (win_valid),
    .amp_met (amp_metric),
    .var_met (var_metric),
    .crs     (carrier_sense)
  );
endmodule

// File: tb/acq_sig_detect_tb.sv
`timescale 1ns/1ps
module acq_sig_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_mag = '0;
  logic [7:0]  smp_phase = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        sym_valid, win_valid, carrier_sense;
  logic [15:0] ontime_mag, early_mag, late_mag, amp_metric, var_metric;
  logic [7:0]  ontime_phase;

  always #2.5 clk = ~clk;

  acq_sig_detect dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_mag(smp_mag), .smp_phase(smp_phase),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sym_valid(sym_valid), .ontime_mag(ontime_mag), .ontime_phase(ontime_phase),
    .early_mag(early_mag), .late_mag(late_mag), .win_valid(win_valid),
    .amp_metric(amp_metric), .var_metric(var_metric), .carrier_sense(carrier_sense));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model state
  int smag[22];
  int sph[22];
  int m_last = 0, m_prev_ph = 0, m_sa = 0, m_sx = 0, m_sx2 = 0, m_cnt = 0;
  int thr_a = 0, thr_p = 65535, m_crs = 0;
  int q_on[$], q_ph[$], q_early[$], q_late[$], q_amp[$], q_var[$], q_crs[$];

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor samples between edges
  always @(negedge clk) begin
    if (!rst) begin
      if (sym_valid) begin
        if (q_on.size() == 0) check("R1 unexpected sym_valid", 1, 0);
        else begin
          check("R2 ontime_mag", int'(ontime_mag), q_on.pop_front());
          check("R2 ontime_phase", int'(ontime_phase), q_ph.pop_front());
          check("R3 early_mag", int'(early_mag), q_early.pop_front());
          check("R4 late_mag", int'(late_mag), q_late.pop_front());
        end
      end
      if (win_valid) begin
        if (q_amp.size() == 0) check("R5 unexpected win_valid", 1, 0);
        else begin
          check("R5 amp_metric", int'(amp_metric), q_amp.pop_front());
          check("R7 var_metric", int'(var_metric), q_var.pop_front());
          check("R9 carrier_sense", int'(carrier_sense), q_crs.pop_front());
        end
      end
    end
  end

  task automatic wr_thr(input int addr, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      0: thr_a = (thr_a & 'hFF00) | val;
      1: thr_a = (thr_a & 'h00FF) | (val << 8);
      2: thr_p = (thr_p & 'hFF00) | val;
      default: thr_p = (thr_p & 'h00FF) | (val << 8);
    endcase
  endtask

  // fill one symbol: peak pk at p, optional tie at tie_p, peak phase ph
  task automatic gen_sym(input int p, input int pk, input int tie_p, input int ph, input int seed);
    for (int i = 0; i < 22; i++) begin
      smag[i] = ((i * 37 + seed * 11) % 200) + 10;
      sph[i]  = (i * 5 + seed * 3) & 255;
    end
    smag[p] = pk;
    sph[p]  = ph & 255;
    if (tie_p >= 0) smag[tie_p] = pk;
  endtask

  // drive one symbol and record expectations
  task automatic send_sym(input bit gaps);
    int p, d, amp, raw, v;
    p = 0;
    for (int i = 1; i < 22; i++) if (smag[i] > smag[p]) p = i;
    q_on.push_back(smag[p]);
    q_ph.push_back(sph[p]);
    q_early.push_back(p == 0 ? m_last : smag[p-1]);
    q_late.push_back(p == 21 ? 0 : smag[p+1]);
    m_last = smag[21];
    d = (sph[p] - m_prev_ph) & 255;
    if (d >= 128) d -= 256;
    m_prev_ph = sph[p];
    m_sa += smag[p]; m_sx += d; m_sx2 += d * d; m_cnt++;
    if (m_cnt == 16) begin
      amp = (m_sa / 16) & 'hFFFF;
      raw = 16 * m_sx2 - m_sx * m_sx;
      v = raw >> 7;
      if (v > 65535) v = 65535;
      m_crs = ((amp >= thr_a) && (v <= thr_p)) ? 1 : 0;
      q_amp.push_back(amp); q_var.push_back(v); q_crs.push_back(m_crs);
      m_sa = 0; m_sx = 0; m_sx2 = 0; m_cnt = 0;
    end
    for (int i = 0; i < 22; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        smp_valid = 1'b0; smp_mag = 16'hFFFF; smp_phase = 8'hAA;  // junk must be ignored (R1)
      end
      @(negedge clk);
      smp_valid = 1'b1; smp_mag = 16'(smag[i]); smp_phase = 8'(sph[i]);
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    check({tag, " R1 all symbols reported"}, q_on.size(), 0);
    check({tag, " R5 all windows reported"}, q_amp.size(), 0);
    check({tag, " R9 carrier_sense held"}, int'(carrier_sense), m_crs);
  endtask

  task automatic t_reset();
    check("R9 reset carrier_sense", int'(carrier_sense), 0);
    check("R1 reset sym_valid", int'(sym_valid), 0);
    check("R5 reset win_valid", int'(win_valid), 0);
    check("R5 reset amp_metric", int'(amp_metric), 0);
    check("R7 reset var_metric", int'(var_metric), 0);
  endtask

  // R1-R7, R10: peaks sweep positions incl. 0 and 21, ties, constant phase step
  task automatic t_peaks();
    int cur = 0;
    for (int k = 0; k < 16; k++) begin
      int p = (k * 5) % 22;
      cur += 10;
      gen_sym(p, 400 + k * 17, (k % 2 == 1 && p < 20) ? p + 2 : -1, cur, k);
      send_sym(1'b0);
    end
    drain("peaks");
  endtask

  // R1: invalid cycles with junk interleaved; wrapping negative phase step (R6)
  task automatic t_gaps();
    int cur = m_prev_ph;
    for (int k = 0; k < 16; k++) begin
      cur -= 37;
      gen_sym((k * 7 + 3) % 22, 600 + k, -1, cur, k + 40);
      send_sym(1'b1);
    end
    drain("gaps");
  endtask

  // R9 phase test boundary: alternating +-64 gives var 8192
  task automatic alt_window(input int seed);
    int cur = m_prev_ph;
    for (int k = 0; k < 16; k++) begin
      cur += (k % 2 == 0) ? 64 : -64;
      gen_sym(11, 900, -1, cur, k + seed);
      send_sym(1'b0);
    end
  endtask

  task automatic t_phase_thr();
    wr_thr(2, 'hFF); wr_thr(3, 'h1F);   // 8191
    alt_window(60);
    drain("phase below");
    check("R9 phase thr 8191 rejects", m_crs, 0);
    wr_thr(2, 'h00); wr_thr(3, 'h20);   // 8192
    alt_window(80);
    drain("phase equal");
    check("R9 phase thr 8192 accepts", m_crs, 1);
    wr_thr(2, 'hFF); wr_thr(3, 'hFF);   // back to all ones (R10)
  endtask

  // R8/R9 amplitude boundary: constant peak 1000 = 0x03E8
  task automatic const_amp_window(input int seed);
    int cur = m_prev_ph;
    for (int k = 0; k < 16; k++) begin
      cur += 3;
      gen_sym((k * 3) % 22, 1000, -1, cur, k + seed);
      send_sym(1'b0);
    end
  endtask

  task automatic t_amp_thr();
    wr_thr(0, 'hE8); wr_thr(1, 'h03);
    const_amp_window(100);
    drain("amp equal");
    check("R9 amp thr 1000 accepts", m_crs, 1);
    wr_thr(0, 'hE9);                    // R8 low byte only, high byte kept
    const_amp_window(120);
    drain("amp above");
    check("R8 R9 amp thr 1001 rejects", m_crs, 0);
    wr_thr(0, 'h00); wr_thr(1, 'h00);   // R10 zero passes
    const_amp_window(140);
    drain("amp zero");
    check("R10 amp thr zero accepts", m_crs, 1);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_peaks();
    t_gaps();
    t_phase_thr();
    t_amp_thr();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule